// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Controller

This block is the serial command front end of a small byte-addressed nonvolatile memory. A host selects it with an active-low chip select, clocks command bytes in on a serial data input with an idle-low serial clock, and receives read data on a serial data output that changes on falling clock edges. The block decodes one opcode per selection. It sequences a 16-bit address and the data bytes that follow, and it keeps the write-enable latch and the busy flag that gate every modification.

Writes to the array and to the status register are held back until chip select rises. They are committed only if the transfer held a whole number of the bytes that the command needs, and only if the write-enable latch was set. A commit starts an internal write cycle of `WR_CYCLES` system clocks that stands in for programming time. The latch clears by itself when that cycle ends. While the cycle runs, only the status read is accepted. The serial clock, chip select and data input are sampled in the system clock domain, and the serial clock must run well below the system clock.

Top module: `spi_ee_top`

## Requirements
- R1: After reset the status byte reads 0x00, and `miso_oe` is low while the block is not selected.
- R2: An opcode is accepted only when its upper nibble is zero, and bit 3 is ignored. Low bits 110 (e.g. 0x06 or 0x0E) set the write-enable bit, which is status bit 1. Low bits 100 (0x04) clear it.
- R3: A write-array or write-status command issued while the write-enable bit is 0 changes neither the array nor the status register, and starts no busy cycle.
- R4: Array write (low bits 010) takes a 16-bit address and data bytes, and commits them at chip select rise to consecutive addresses. Array read (low bits 011) takes a 16-bit address and then streams bytes from consecutive addresses. All fields are MSB first: input is sampled on rising serial clock edges and output changes on falling edges.
- R5: A commit sets the busy bit (status bit 0) for `WR_CYCLES` system clocks. When the busy bit clears, the write-enable bit is cleared too.
- R6: While busy, any opcode other than the status read is ignored: a read drives no output and a write-enable has no effect.
- R7: The status read (low bits 101) returns the live status byte after the opcode and repeats it for every further byte until deselect.
- R8: An unrecognised opcode never enables the serial output and changes no state.
- R9: A modifying command whose bit count at chip select rise is not a whole number of bytes is discarded. The array, the protect fields and the write-enable bit all keep their values.
- R10: Write status (low bits 001, one data byte) updates only the protect-enable bit 7 and the block-protect bits 3:2. The other bits read back from live state, and bits 6:4 read 0.
- R11: Address bits above log2(`DEPTH`) are ignored, so addresses that differ only in those bits alias.
- R12: `miso_oe` is high only while chip select is low and a read or status-read data phase is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial data into the block |
| miso | output | 1 | Serial data out of the block |
| miso_oe | output | 1 | Output enable for the serial data out pin |

## Verification
The main function is tried with multi-byte array writes followed by streaming reads at the same base address, which separates correct address increment and MSB-first order from shifted or reordered data. The same writes are repeated with the latch cleared, with a transfer cut three bits short, and during a busy cycle. This tells the gating checks apart from the byte-count check and from the busy lockout. Status reads are taken both inside and after a busy cycle to separate the live busy and latch bits from the stored protect fields. Aliasing high address bits and opcodes that differ only in the upper nibble or in the don't-care bit show whether decode looks at exactly the bits it should.

// File: rtl/spi_ee_pkg.sv
// Package: shared command codes, phase encoding and status bit positions
// for the serial EEPROM slave. Assumes opcodes are 8 bits wide.
package spi_ee_pkg;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_WREN,
        CMD_WRDI,
        CMD_RDSR,
        CMD_WRSR,
        CMD_READ,
        CMD_WRITE
    } cmd_e;

    typedef enum logic [2:0] {
        PH_OPC,
        PH_ADDR,
        PH_WDATA,
        PH_RDOUT,
        PH_STOUT,
        PH_SKIP
    } phase_e;

    localparam int BCNT_W = 8;

    // Map an opcode byte to a command; upper nibble must be zero, bit 3 ignored.
    function automatic cmd_e decode_op(input logic [7:0] op);
        cmd_e c;
        c = CMD_NONE;
        if (op[7:4] == 4'h0) begin
            case (op[2:0])
                3'b110:  c = CMD_WREN;
                3'b100:  c = CMD_WRDI;
                3'b101:  c = CMD_RDSR;
                3'b001:  c = CMD_WRSR;
                3'b011:  c = CMD_READ;
                3'b010:  c = CMD_WRITE;
                default: c = CMD_NONE;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/spi_ee_link.sv
// Serial link layer: detects serial clock edges in the system clock domain,
// shifts input bits in MSB first, counts bits and bytes of the current
// selection, and shifts output bytes out on falling edges.
// Assumes sck, cs_n and mosi are synchronous to clk and that sck half
// periods span several clk cycles.
module spi_ee_link
    import spi_ee_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              mosi,
    input  logic              out_active,
    input  logic [7:0]        tx_byte,
    output logic              cs_end,
    output logic              byte_done,
    output logic [7:0]        rx_byte,
    output logic [BCNT_W-1:0] byte_cnt,
    output logic [2:0]        bit_idx,
    output logic              load_tick,
    output logic              miso,
    output logic              miso_oe
);

    logic       sck_q;
    logic       cs_q;
    logic       rise;
    logic       fall;
    logic       cs_start;
    logic [7:0] out_sr;

    // Previous-cycle copies of serial clock and chip select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
        end
    end

    always_comb begin
        rise      = !cs_n && sck && !sck_q;
        fall      = !cs_n && !sck && sck_q;
        cs_start  = !cs_n && cs_q;
        cs_end    = cs_n && !cs_q;
        load_tick = fall && out_active && (bit_idx == 3'd0);
    end

    // Input shifter with bit and saturating byte counters per selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_byte  <= '0;
            bit_idx  <= '0;
            byte_cnt <= '0;
        end else if (cs_start) begin
            bit_idx  <= '0;
            byte_cnt <= '0;
        end else if (rise) begin
            rx_byte <= {rx_byte[6:0], mosi};
            bit_idx <= bit_idx + 3'd1;
            if (bit_idx == 3'd7 && byte_cnt != {BCNT_W{1'b1}})
                byte_cnt <= byte_cnt + 1'b1;
        end
    end

    // One-cycle pulse after the eighth bit of a byte has been sampled.
    always_ff @(posedge clk) begin
        if (!rst_n) byte_done <= 1'b0;
        else        byte_done <= rise && (bit_idx == 3'd7);
    end

    // Output shifter: loads at byte boundaries, shifts on other falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n)                  out_sr <= '0;
        else if (load_tick)          out_sr <= tx_byte;
        else if (fall && out_active) out_sr <= {out_sr[6:0], 1'b0};
    end

    assign miso    = out_sr[7];
    assign miso_oe = !cs_n && out_active;

endmodule

// File: rtl/spi_ee_ctrl.sv
// Command sequencer: decodes the opcode, collects address and data bytes,
// buffers write data, picks the output byte, and judges at deselect
// whether a command is complete enough to act on.
// Assumes PAGE is a power of two; write data beyond PAGE bytes wraps
// within the buffer.
module spi_ee_ctrl
    import spi_ee_pkg::*;
#(
    parameter int AW   = 8,
    parameter int PAGE = 8,
    localparam int PW  = (PAGE > 1) ? $clog2(PAGE) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_end,
    input  logic              byte_done,
    input  logic [7:0]        rx_byte,
    input  logic [BCNT_W-1:0] byte_cnt,
    input  logic [2:0]        bit_idx,
    input  logic              load_tick,
    input  logic              busy,
    input  logic              wel,
    input  logic [7:0]        status,
    input  logic [7:0]        rd_data,
    input  logic [PW-1:0]     copy_idx,
    output logic              out_active,
    output logic [7:0]        tx_byte,
    output logic [AW-1:0]     rd_addr,
    output logic              set_wel,
    output logic              clr_wel,
    output logic              sr_we,
    output logic [7:0]        sr_wdata,
    output logic              wr_go,
    output logic [AW-1:0]     wr_base,
    output logic [PW:0]       wr_len,
    output logic [7:0]        copy_data
);

    localparam logic [PW:0] LEN_FULL = (PW+1)'(PAGE);

    phase_e        phase;
    cmd_e          cmd;
    cmd_e          dec;
    logic [7:0]    addr_hi;
    logic [AW-1:0] addr;
    logic [7:0]    sr_data;
    logic [PW:0]   wlen;
    logic [7:0]    wbuf [PAGE];
    logic [15:0]   full_addr;
    logic [7:0]    dpos;
    logic [PW-1:0] widx;
    logic          whole;

    // Opcode decode with busy lockout, and buffer slot of the current byte.
    always_comb begin
        dec = decode_op(rx_byte);
        if (busy && dec != CMD_RDSR) dec = CMD_NONE;
        full_addr = {addr_hi, rx_byte};
        dpos      = byte_cnt - 8'd4;
        widx      = dpos[PW-1:0];
        whole     = (bit_idx == 3'd0);
    end

    // Deselect actions, taken only for whole-byte transfers of the right length.
    always_comb begin
        set_wel = cs_end && whole && cmd == CMD_WREN && byte_cnt == 8'd1;
        clr_wel = cs_end && whole && cmd == CMD_WRDI && byte_cnt == 8'd1;
        sr_we   = cs_end && whole && cmd == CMD_WRSR && byte_cnt == 8'd2
                  && wel && !busy;
        wr_go   = cs_end && whole && cmd == CMD_WRITE && byte_cnt >= 8'd4
                  && wel && !busy;
    end

    // Phase sequencing, address capture and read address increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_OPC;
            cmd     <= CMD_NONE;
            addr_hi <= '0;
            addr    <= '0;
            sr_data <= '0;
            wlen    <= '0;
        end else if (cs_end) begin
            phase <= PH_OPC;
            cmd   <= CMD_NONE;
        end else if (load_tick && phase == PH_RDOUT) begin
            addr <= addr + 1'b1;
        end else if (byte_done) begin
            case (phase)
                PH_OPC: begin
                    cmd  <= dec;
                    wlen <= '0;
                    case (dec)
                        CMD_RDSR:            phase <= PH_STOUT;
                        CMD_READ, CMD_WRITE: phase <= PH_ADDR;
                        CMD_WRSR:            phase <= PH_WDATA;
                        default:             phase <= PH_SKIP;
                    endcase
                end
                PH_ADDR: begin
                    if (byte_cnt == 8'd2) begin
                        addr_hi <= rx_byte;
                    end else begin
                        addr  <= full_addr[AW-1:0];
                        phase <= (cmd == CMD_READ) ? PH_RDOUT : PH_WDATA;
                    end
                end
                PH_WDATA: begin
                    if (cmd == CMD_WRSR) begin
                        if (byte_cnt == 8'd2) sr_data <= rx_byte;
                    end else if (wlen != LEN_FULL) begin
                        wlen <= wlen + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Write data buffer, filled one slot per received data byte.
    always_ff @(posedge clk) begin
        if (byte_done && !cs_end && phase == PH_WDATA && cmd == CMD_WRITE)
            wbuf[widx] <= rx_byte;
    end

    always_comb begin
        out_active = (phase == PH_RDOUT) || (phase == PH_STOUT);
        tx_byte    = (phase == PH_STOUT) ? status : rd_data;
        rd_addr    = addr;
        wr_base    = addr;
        wr_len     = wlen;
        sr_wdata   = sr_data;
        copy_data  = wbuf[copy_idx];
    end

endmodule

// File: rtl/spi_ee_store.sv
// Storage and write cycle: byte array, status fields, write-enable latch
// and the busy timer that stands in for programming time. Buffered write
// data is copied into the array one byte per clock at the start of busy.
// Assumes DEPTH is a power of two and WR_CYCLES >= PAGE.
module spi_ee_store #(
    parameter int DEPTH     = 256,
    parameter int PAGE      = 8,
    parameter int WR_CYCLES = 64,
    localparam int AW       = $clog2(DEPTH),
    localparam int PW       = (PAGE > 1) ? $clog2(PAGE) : 1,
    localparam int TW       = $clog2(WR_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_wel,
    input  logic          clr_wel,
    input  logic          sr_we,
    input  logic [7:0]    sr_wdata,
    input  logic          wr_go,
    input  logic [AW-1:0] wr_base,
    input  logic [PW:0]   wr_len,
    input  logic [7:0]    copy_data,
    input  logic [AW-1:0] rd_addr,
    output logic          busy,
    output logic          wel,
    output logic [7:0]    status,
    output logic [7:0]    rd_data,
    output logic [PW-1:0] copy_idx
);

    localparam logic [TW-1:0] TMR_LAST = TW'(WR_CYCLES - 1);

    logic [7:0]    mem [DEPTH];
    logic          pe;
    logic [1:0]    bp;
    logic [TW-1:0] tmr;
    logic [AW-1:0] base;
    logic [PW:0]   len;
    logic [PW:0]   cpy;
    logic          copy_en;
    logic [AW-1:0] waddr;

    // Latch, protect fields and busy timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel  <= 1'b0;
            pe   <= 1'b0;
            bp   <= '0;
            busy <= 1'b0;
            tmr  <= '0;
            base <= '0;
            len  <= '0;
        end else if (set_wel) begin
            wel <= 1'b1;
        end else if (clr_wel) begin
            wel <= 1'b0;
        end else if (sr_we) begin
            pe   <= sr_wdata[7];
            bp   <= sr_wdata[3:2];
            busy <= 1'b1;
            tmr  <= '0;
            len  <= '0;
        end else if (wr_go) begin
            busy <= 1'b1;
            tmr  <= '0;
            base <= wr_base;
            len  <= wr_len;
        end else if (busy) begin
            if (tmr == TMR_LAST) begin
                busy <= 1'b0;
                wel  <= 1'b0;
            end else begin
                tmr <= tmr + 1'b1;
            end
        end
    end

    always_comb begin
        copy_en  = busy && (cpy != len);
        waddr    = base + AW'(cpy);
        copy_idx = cpy[PW-1:0];
        status   = {pe, 3'b000, bp, wel, busy};
        rd_data  = mem[rd_addr];
    end

    // Copy index that walks the buffered bytes during the busy cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                cpy <= '0;
        else if (wr_go || sr_we)   cpy <= '0;
        else if (copy_en)          cpy <= cpy + 1'b1;
    end

    // Array write port.
    always_ff @(posedge clk) begin
        if (copy_en) mem[waddr] <= copy_data;
    end

endmodule

// File: rtl/spi_ee_top.sv
// Top of the serial EEPROM slave: connects the link layer, the command
// sequencer and the storage. Serial inputs must be synchronous to clk and
// the serial clock at least four times slower than clk.
module spi_ee_top #(
    parameter int DEPTH     = 256,
    parameter int PAGE      = 8,
    parameter int WR_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    output logic miso,
    output logic miso_oe
);

    import spi_ee_pkg::*;

    localparam int AW = $clog2(DEPTH);
    localparam int PW = (PAGE > 1) ? $clog2(PAGE) : 1;

    logic              cs_end;
    logic              byte_done;
    logic [7:0]        rx_byte;
    logic [BCNT_W-1:0] byte_cnt;
    logic [2:0]        bit_idx;
    logic              load_tick;
    logic              out_active;
    logic [7:0]        tx_byte;
    logic [AW-1:0]     rd_addr;
    logic              set_wel;
    logic              clr_wel;
    logic              sr_we;
    logic [7:0]        sr_wdata;
    logic              wr_go;
    logic [AW-1:0]     wr_base;
    logic [PW:0]       wr_len;
    logic [7:0]        copy_data;
    logic [PW-1:0]     copy_idx;
    logic              busy_w;
    logic              wel_w;
    logic [7:0]        status;
    logic [7:0]        rd_data;

    spi_ee_link u_link (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .out_active(out_active), .tx_byte(tx_byte), .cs_end(cs_end),
        .byte_done(byte_done), .rx_byte(rx_byte), .byte_cnt(byte_cnt),
        .bit_idx(bit_idx), .load_tick(load_tick), .miso(miso),
        .miso_oe(miso_oe)
    );

    spi_ee_ctrl #(.AW(AW), .PAGE(PAGE)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_end(cs_end), .byte_done(byte_done),
        .rx_byte(rx_byte), .byte_cnt(byte_cnt), .bit_idx(bit_idx),
        .load_tick(load_tick), .busy(busy_w), .wel(wel_w), .status(status),
        .rd_data(rd_data), .copy_idx(copy_idx), .out_active(out_active),
        .tx_byte(tx_byte), .rd_addr(rd_addr), .set_wel(set_wel),
        .clr_wel(clr_wel), .sr_we(sr_we), .sr_wdata(sr_wdata), .wr_go(wr_go),
        .wr_base(wr_base), .wr_len(wr_len), .copy_data(copy_data)
    );

    spi_ee_store #(.DEPTH(DEPTH), .PAGE(PAGE), .WR_CYCLES(WR_CYCLES)) u_store (
        .clk(clk), .rst_n(rst_n), .set_wel(set_wel), .clr_wel(clr_wel),
        .sr_we(sr_we), .sr_wdata(sr_wdata), .wr_go(wr_go), .wr_base(wr_base),
        .wr_len(wr_len), .copy_data(copy_data), .rd_addr(rd_addr),
        .busy(busy_w), .wel(wel_w), .status(status), .rd_data(rd_data),
        .copy_idx(copy_idx)
    );

endmodule

// File: rtl/spi_ee_chk.sv
// Checker for the serial EEPROM slave: temporal rules on the output enable,
// the serial output timing, the write-enable latch and the busy flag.
// Attached to every instance of the top module by the bind below.
module spi_ee_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sck,
    input logic miso,
    input logic miso_oe,
    input logic busy,
    input logic wel
);

    // R12
    oe_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe |-> !cs_n);

    // R4
    miso_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miso_oe && $past(miso_oe) && miso != $past(miso)) |-> !sck);

    // R3
    commit_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wel));

    // R5
    latch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);

    // R6
    no_latch_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> !$past(busy));

endmodule

bind spi_ee_top spi_ee_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .miso(miso),
    .miso_oe(miso_oe), .busy(busy_w), .wel(wel_w)
);

// File: tb/tb_spi_ee_top.sv
module tb_spi_ee_top;

    localparam int WRC = 600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic miso;
    logic miso_oe;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] mbyte = 8'h00;
    int         mcnt = 0;

    always #2.5 clk = ~clk;

    spi_ee_top #(.DEPTH(256), .PAGE(8), .WR_CYCLES(WRC)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe)
    );

    task automatic push(input string tag, input logic [7:0] v);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic sbit(input logic b);
        @(negedge clk) mosi = b;
        repeat (4) @(negedge clk);
        sck = 1'b1;
        repeat (4) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic sbyte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) sbit(b[i]);
    endtask

    task automatic cs_lo();
        @(negedge clk) cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_hi();
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic cmd1(input logic [7:0] op);
        cs_lo(); sbyte(op); cs_hi();
    endtask

    task automatic rdsr(input string tag, input int n, input logic [7:0] e);
        cs_lo();
        sbyte(8'h05);
        for (int i = 0; i < n; i++) begin
            push(tag, e);
            sbyte(8'h00);
        end
        cs_hi();
    endtask

    task automatic rd_raw(input string tag, input logic [15:0] a, input int n);
        cs_lo();
        chk({tag, " oe idle"}, {7'd0, miso_oe}, 8'h00);
        sbyte(8'h03); sbyte(a[15:8]); sbyte(a[7:0]);
        for (int i = 0; i < n; i++) sbyte(8'h00);
        cs_hi();
        chk({tag, " oe after"}, {7'd0, miso_oe}, 8'h00);
    endtask

    task automatic wait_done();
        repeat (WRC + 50) @(negedge clk);
    endtask

    // Monitor: assembles driven output bytes and compares against the queue.
    initial begin
        forever begin
            @(posedge sck or posedge cs_n);
            if (cs_n) mcnt = 0;
            else if (miso_oe) begin
                mbyte = {mbyte[6:0], miso};
                mcnt++;
                if (mcnt == 8) begin
                    mcnt = 0;
                    n_chk++;
                    if (exp_q.size() == 0) begin
                        n_bad++;
                        $display("FAIL R12: actual driven byte %02h expected no output", mbyte);
                    end else begin
                        automatic logic [7:0] e = exp_q.pop_front();
                        automatic string t = tag_q.pop_front();
                        if (mbyte !== e) begin
                            n_bad++;
                            $display("FAIL %s: actual %02h expected %02h", t, mbyte, e);
                        end
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog (all R): actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 oe", {7'd0, miso_oe}, 8'h00);
        rdsr("R1", 1, 8'h00);

        // R2: latch set, cleared, and set with don't-care bit 3
        cmd1(8'h06); rdsr("R2 set", 1, 8'h02);
        cmd1(8'h04); rdsr("R2 clr", 1, 8'h00);
        cmd1(8'h0E); rdsr("R2 bit3", 1, 8'h02);

        // R4/R5/R6: write three bytes, observe busy, blocked read during busy
        cs_lo(); sbyte(8'h02); sbyte(8'h00); sbyte(8'h10);
        sbyte(8'h11); sbyte(8'h22); sbyte(8'h33); cs_hi();
        rdsr("R5 busy", 1, 8'h03);
        cs_lo(); sbyte(8'h03); sbyte(8'h00); sbyte(8'h10);
        repeat (4) sbit(1'b0);
        chk("R6 read blocked", {7'd0, miso_oe}, 8'h00);
        repeat (4) sbit(1'b0);
        cs_hi();
        wait_done();
        // R7: repeated status bytes after the cycle; R5 latch cleared
        rdsr("R5 R7 done", 3, 8'h00);
        push("R4 b0", 8'h11); push("R4 b1", 8'h22); push("R4 b2", 8'h33);
        rd_raw("R4", 16'h0010, 3);

        // R3: write and status write without latch have no effect
        cs_lo(); sbyte(8'h02); sbyte(8'h00); sbyte(8'h11); sbyte(8'h55); cs_hi();
        cs_lo(); sbyte(8'h01); sbyte(8'h8C); cs_hi();
        rdsr("R3 status", 1, 8'h00);
        push("R3 b0", 8'h11); push("R3 b1", 8'h22);
        rd_raw("R3", 16'h0010, 2);

        // R10: status write keeps only protect fields
        cmd1(8'h06);
        cs_lo(); sbyte(8'h01); sbyte(8'hFF); cs_hi();
        rdsr("R10 busy", 1, 8'h8F);
        wait_done();
        rdsr("R10 R7", 3, 8'h8C);

        // R9: truncated write ignored, latch kept
        cmd1(8'h06);
        cs_lo(); sbyte(8'h02); sbyte(8'h00); sbyte(8'h10); sbyte(8'h77);
        sbit(1'b1); sbit(1'b0); sbit(1'b1); cs_hi();
        repeat (40) @(negedge clk);
        rdsr("R9 status", 1, 8'h8E);
        push("R9 data", 8'h11);
        rd_raw("R9", 16'h0010, 1);

        // R8: upper nibble set and unknown low bits are rejected
        cmd1(8'h04);
        cmd1(8'h16);
        rdsr("R8 nibble", 1, 8'h8C);
        cs_lo(); sbyte(8'h07);
        repeat (4) sbit(1'b1);
        chk("R8 oe", {7'd0, miso_oe}, 8'h00);
        repeat (4) sbit(1'b1);
        cs_hi();
        rdsr("R8 status", 1, 8'h8C);

        // R11: high address bits alias
        cmd1(8'h06);
        cs_lo(); sbyte(8'h02); sbyte(8'h12); sbyte(8'h34);
        sbyte(8'hA5); sbyte(8'h5A); cs_hi();
        wait_done();
        push("R11 b0", 8'hA5); push("R11 b1", 8'h5A);
        rd_raw("R11", 16'h0034, 2);
        push("R11 alias", 8'hA5);
        rd_raw("R11 hi", 16'hFF34, 1);

        repeat (10) @(negedge clk);
        chk("R4 pending", 8'(exp_q.size()), 8'h00);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule